// File: doc/BRIEF.md
# Reset Source Combiner with Cause Flags

This block gathers every reason a processor core can be reset and folds them into one active-high system reset line. The reasons are power-on, brown-out, a low level on the external reset pin, a software reset request, a watchdog timeout outside the low-power states, a conflict between hard traps, an illegal opcode and the use of an uninitialized working register as a pointer. Hardware faults reach the output through a purely combinational path, so the reset takes effect without waiting for a clock edge. Release is always taken on a clock edge. The pin is released through a two-flop synchronizer. Brown-out and power-on release after a programmable power-up delay.

Next to the reset logic sits a 16-bit cause register. Firmware reads it after a reset to find out why the reset happened, and clears it afterwards. Each flag is sticky and is set by its own hardware event. Firmware may overwrite the register at any time, and such a write never causes a reset. A watchdog timeout while the core sleeps or idles only sets its flag. It acts as a wake-up and does not reset the core.

Top module: `rst_cause_hub`

## Requirements
- R1: While `rst_n` (power-on) is low, `sys_rst` is 1 and `status` reads 0x0003: bits 0 (power-on) and 1 (brown-out) are set and every other bit is clear.
- R2: Each of the following drives `sys_rst` to 1 within the same cycle, before any clock edge: `ext_rst_n` low, `bor_req` high, `illop_req`, `uninit_req`, a trap conflict, or `wdt_tmo` while neither `sleep_st` nor `idle_st` is high.
- R3: A `swr_req` sampled high at a rising edge makes `sys_rst` 1 for exactly the following cycle, unless another source is active.
- R4: `ext_rst_n` passes through a two-flop synchronizer. After the pin returns high, `sys_rst` stays 1 until the second rising edge that samples it high. Status bit 7 is set at the edge after the second synchronizer stage has captured a low.
- R5: After `rst_n` rises, and after `bor_req` falls, `sys_rst` stays 1 for PWRT_CYCLES more rising edges. `bor_req` sets status bit 1.
- R6: A reset caused by a watchdog timeout, an illegal opcode, an uninitialized register or a trap conflict holds `sys_rst` high until the first rising edge at which its source is no longer active.
- R7: A trap conflict exists when two or more bits of `trap_pend` are high in the same cycle. It resets the core and sets status bit 15. A single pending trap does neither.
- R8: `wdt_tmo` while `sleep_st` or `idle_st` is high sets status bit 4 and does not assert `sys_rst`.
- R9: The following inputs each set their own bit at the next rising edge: `illop_req` or `uninit_req` set bit 14, `swr_req` sets bit 6, `wdt_tmo` sets bit 4, `sleep_st` sets bit 3 and `idle_st` sets bit 2. Bit 0 is set only by power-on.
- R10: `pwrsav_req` clears status bit 4 at the next rising edge.
- R11: `wr_en` loads `wr_data` into bits 15, 14, 7, 6, 4, 3, 2, 1 and 0. Bits 13 to 8 and bit 5 always read 0. A write never asserts `sys_rst`.
- R12: If a hardware event sets a flag in the same cycle that a write or a power-save event would clear it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, already glitch-filtered |
| bor_req | input | 1 | Supply below the brown-out trip point |
| swr_req | input | 1 | Software reset instruction executed (one-cycle pulse) |
| wdt_tmo | input | 1 | Watchdog timeout |
| trap_pend | input | NTRAP | Hard trap pending flags |
| illop_req | input | 1 | Illegal opcode detected |
| uninit_req | input | 1 | Uninitialized register used as an address pointer |
| sleep_st | input | 1 | Core is in sleep |
| idle_st | input | 1 | Core is in idle |
| pwrsav_req | input | 1 | Power-save instruction executed |
| wr_en | input | 1 | Write strobe for the cause register |
| wr_data | input | 16 | Write data for the cause register |
| sys_rst | output | 1 | System reset, active high |
| status | output | 16 | Cause register read value |

## Verification
The bench goes after the release timing, where an off-by-one is easy to make. A synchronizer that is one stage short releases the pin reset a cycle early. A software reset that is not stretched never shows up on the output. A power-up timer that starts counting while `bor_req` is still high releases the reset too soon.

It also goes after collisions. A watchdog timeout during sleep or idle must not reset the core. A write or a power-save event in the same cycle as a hardware set must not clear the flag. A single pending trap must not be taken for a conflict. A design that got any of these wrong would either reset the core when it should not, or lose the cause that firmware relies on. Writes of all ones and all zeros expose unimplemented bits that are not held at zero, and they show that a write never resets the core.

// File: rtl/rst_pkg.sv
package rst_pkg;
  localparam int unsigned STAT_W = 16;

  // Flag positions; firmware decodes these.
  localparam int unsigned B_POR  = 0;
  localparam int unsigned B_BOR  = 1;
  localparam int unsigned B_IDL  = 2;
  localparam int unsigned B_SLP  = 3;
  localparam int unsigned B_WDT  = 4;
  localparam int unsigned B_SWR  = 6;
  localparam int unsigned B_EXT  = 7;
  localparam int unsigned B_ILL  = 14;
  localparam int unsigned B_TRAP = 15;

  localparam logic [STAT_W-1:0] IMPL_MASK =
    (16'd1 << B_POR) | (16'd1 << B_BOR) | (16'd1 << B_IDL) | (16'd1 << B_SLP) |
    (16'd1 << B_WDT) | (16'd1 << B_SWR) | (16'd1 << B_EXT) | (16'd1 << B_ILL) |
    (16'd1 << B_TRAP);

  localparam logic [STAT_W-1:0] POR_VALUE = (16'd1 << B_POR) | (16'd1 << B_BOR);

  typedef struct packed {
    logic trap;
    logic ill;
    logic ext;
    logic swr;
    logic wdt;
    logic slp;
    logic idl;
    logic bor;
  } cause_t;
endpackage

// File: rtl/rst_ext_sync.sv
module rst_ext_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic pin_sync_n
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  always_comb begin
    stg_d[0] = pin_n;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '1;
    else        stg_q <= stg_d;
  end

  assign pin_sync_n = stg_q[STAGES-1];

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_chk
      assert_sync_lag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !stg_q[g-1] |=> !stg_q[g]);
    end
  endgenerate
endmodule

// File: rtl/rst_pwrt_timer.sv
module rst_pwrt_timer #(
  parameter int unsigned CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bor_req,
  output logic busy_o
);
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = bor_req || (cnt_q != '0);
    if (bor_req) cnt_d = LOAD;
    else         cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= LOAD;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

  generate
    if (CYCLES > 0) begin : g_chk
      assert_bor_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bor_req) |-> busy_o);
    end
  endgenerate
endmodule

// File: rtl/rst_status_reg.sv
module rst_status_reg
  import rst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_i,
  input  logic              clr_wdt_i,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] status_o
);
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] stat_d;
  logic [STAT_W-1:0] base;
  logic              upd;

  always_comb begin
    base = wr_en ? wr_data : stat_q;
    if (clr_wdt_i) base[B_WDT] = 1'b0;
    stat_d = (base | set_i) & IMPL_MASK;
    upd    = wr_en || clr_wdt_i || (set_i != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stat_q <= POR_VALUE;
    else if (upd) stat_q <= stat_d;
  end

  assign status_o = stat_q;

  assert_hw_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i)));

  assert_pwrsav_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wdt_i && !set_i[B_WDT]) |=> !status_o[B_WDT]);
endmodule

// File: rtl/rst_cause_hub.sv
module rst_cause_hub
  import rst_pkg::*;
#(
  parameter int unsigned NTRAP       = 4,
  parameter int unsigned PWRT_CYCLES = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_rst_n,
  input  logic              bor_req,
  input  logic              swr_req,
  input  logic              wdt_tmo,
  input  logic [NTRAP-1:0]  trap_pend,
  input  logic              illop_req,
  input  logic              uninit_req,
  input  logic              sleep_st,
  input  logic              idle_st,
  input  logic              pwrsav_req,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic              sys_rst,
  output logic [STAT_W-1:0] status
);
  logic              ext_sync_n;
  logic              pwrt_busy;
  logic              trap_conflict;
  logic              wdt_rst;
  logic              async_now;
  logic              hold_q;
  logic              hold_d;
  cause_t            cause;
  logic [STAT_W-1:0] set_vec;

  rst_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(ext_rst_n), .pin_sync_n(ext_sync_n)
  );

  rst_pwrt_timer #(.CYCLES(PWRT_CYCLES)) u_pwrt (
    .clk(clk), .rst_n(rst_n), .bor_req(bor_req), .busy_o(pwrt_busy)
  );

  // Two or more pending bits: clearing the lowest one leaves something set.
  always_comb begin
    trap_conflict = (trap_pend & (trap_pend - 1'b1)) != '0;
    wdt_rst       = wdt_tmo && !(sleep_st || idle_st);
    async_now     = wdt_rst || illop_req || uninit_req || trap_conflict;
    hold_d        = async_now || swr_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  always_comb begin
    cause.trap = trap_conflict;
    cause.ill  = illop_req || uninit_req;
    cause.ext  = !ext_sync_n;
    cause.swr  = swr_req;
    cause.wdt  = wdt_tmo;
    cause.slp  = sleep_st;
    cause.idl  = idle_st;
    cause.bor  = bor_req;
    set_vec         = '0;
    set_vec[B_TRAP] = cause.trap;
    set_vec[B_ILL]  = cause.ill;
    set_vec[B_EXT]  = cause.ext;
    set_vec[B_SWR]  = cause.swr;
    set_vec[B_WDT]  = cause.wdt;
    set_vec[B_SLP]  = cause.slp;
    set_vec[B_IDL]  = cause.idl;
    set_vec[B_BOR]  = cause.bor;
  end

  rst_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_wdt_i(pwrsav_req),
    .wr_en(wr_en), .wr_data(wr_data), .status_o(status)
  );

  assign sys_rst = !rst_n || !ext_rst_n || !ext_sync_n || async_now ||
                   hold_q || bor_req || pwrt_busy;

  assert_swr_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    swr_req |=> sys_rst);

  assert_trap_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_conflict |=> status[B_TRAP]);
endmodule

// File: tb/sim_rst_cause_hub.sv
`timescale 1ns/1ps
module sim_rst_cause_hub;
  localparam int NT = 4;
  localparam int P  = 8;
  localparam logic [15:0] MASK = 16'hC0DF;

  logic clk = 1'b0;
  logic rst_n;
  logic ext_n, bor, swr, wdt, ill, uni, slp, idl, psv, we;
  logic [NT-1:0] tp;
  logic [15:0]   wd;
  logic          sys_rst;
  logic [15:0]   status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic m_s1, m_s2, m_hold;
  int   m_cnt;
  logic [15:0] m_stat;

  always #10 clk = ~clk;

  rst_cause_hub #(.NTRAP(NT), .PWRT_CYCLES(P), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_rst_n(ext_n), .bor_req(bor), .swr_req(swr),
    .wdt_tmo(wdt), .trap_pend(tp), .illop_req(ill), .uninit_req(uni),
    .sleep_st(slp), .idle_st(idl), .pwrsav_req(psv), .wr_en(we), .wr_data(wd),
    .sys_rst(sys_rst), .status(status)
  );

  function automatic logic conflict(input logic [NT-1:0] v);
    return $countones(v) > 1;
  endfunction

  function automatic logic anow();
    return (wdt && !(slp || idl)) || ill || uni || conflict(tp);
  endfunction

  function automatic logic exp_rst();
    return !ext_n || !m_s2 || anow() || m_hold || bor || (m_cnt != 0);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_in();
    ext_n = 1; bor = 0; swr = 0; wdt = 0; ill = 0; uni = 0;
    slp = 0; idl = 0; psv = 0; we = 0; wd = '0; tp = '0;
  endtask

  // Called at a falling edge with inputs already driven.
  task automatic cycle(input string tag);
    logic [15:0] base;
    logic [15:0] sets;
    #1;
    chk({tag, " sys_rst"}, {15'd0, sys_rst}, {15'd0, exp_rst()});
    sets = '0;
    sets[15] = conflict(tp);
    sets[14] = ill || uni;
    sets[7]  = !m_s2;
    sets[6]  = swr;
    sets[4]  = wdt;
    sets[3]  = slp;
    sets[2]  = idl;
    sets[1]  = bor;
    base = we ? wd : m_stat;
    if (psv) base[4] = 1'b0;
    @(posedge clk);
    m_stat = (base | sets) & MASK;
    m_hold = anow() || swr;
    m_s2   = m_s1;
    m_s1   = ext_n;
    if (bor) m_cnt = P;
    else if (m_cnt != 0) m_cnt = m_cnt - 1;
    @(negedge clk);
    chk({tag, " status"}, status, m_stat);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset sys_rst", {15'd0, sys_rst}, 16'd1);
    chk("R1 reset status", status, 16'h0003);
    rst_n = 1;
    m_s1 = 1; m_s2 = 1; m_hold = 0; m_cnt = P; m_stat = 16'h0003;
    // R5: power-up delay after release
    for (int i = 0; i < P + 2; i++) cycle("R5 power-up");
    chk("R5 released", {15'd0, sys_rst}, 16'd0);

    // R3: software reset stretch
    swr = 1; cycle("R3"); swr = 0;
    chk("R3 stretch", {15'd0, sys_rst}, 16'd1);
    cycle("R3"); cycle("R3");
    chk("R3 one cycle only", {15'd0, sys_rst}, 16'd0);

    // R4: pin reset and synchronized release
    ext_n = 0; cycle("R4"); cycle("R4"); cycle("R4"); ext_n = 1;
    cycle("R4 release"); cycle("R4 release"); cycle("R4 release");
    chk("R4 flag", status & 16'h0080, 16'h0080);

    // R2 / R6: async sources
    ill = 1; cycle("R2 illop"); ill = 0; cycle("R6 hold"); cycle("R6");
    uni = 1; cycle("R2 uninit"); uni = 0; cycle("R6 hold"); cycle("R6");
    wdt = 1; cycle("R2 wdt"); wdt = 0; cycle("R6 hold"); cycle("R6");

    // R7: trap conflict
    tp = 4'b0100; cycle("R7 single"); tp = '0; cycle("R7");
    tp = 4'b1001; cycle("R7 conflict"); tp = '0; cycle("R7"); cycle("R7");
    chk("R7 flag", status & 16'h8000, 16'h8000);

    // R8: watchdog during sleep / idle
    we = 1; wd = 16'h0000; cycle("R11 clear"); we = 0; cycle("R11");
    slp = 1; wdt = 1; cycle("R8 sleep"); wdt = 0; cycle("R8");
    slp = 0; idl = 1; wdt = 1; cycle("R8 idle"); wdt = 0; idl = 0; cycle("R8");
    chk("R8 no reset", {15'd0, sys_rst}, 16'd0);

    // R10 / R12: power-save clear and collisions
    psv = 1; cycle("R10"); psv = 0;
    chk("R10 wdt cleared", status & 16'h0010, 16'h0000);
    psv = 1; wdt = 1; slp = 1; cycle("R12 psv vs wdt"); psv = 0; wdt = 0; slp = 0;
    chk("R12 wdt kept", status & 16'h0010, 16'h0010);
    we = 1; wd = 16'h0000; bor = 1; cycle("R12 write vs bor"); we = 0; bor = 0;
    chk("R12 bor kept", status & 16'h0002, 16'h0002);
    for (int i = 0; i < P + 2; i++) cycle("R5 bor release");

    // R11: writes
    we = 1; wd = 16'hFFFF; cycle("R11 ones"); we = 0;
    chk("R11 ones", status, 16'hC0DF);
    chk("R11 no reset", {15'd0, sys_rst}, 16'd0);
    we = 1; wd = 16'h3F20; cycle("R11 unimpl"); we = 0;
    chk("R11 unimpl zero", status, 16'h0000);

    // R9: random mix
    for (int i = 0; i < 3000; i++) begin
      idle_in();
      ext_n = ($urandom_range(0, 39) != 0);
      bor   = ($urandom_range(0, 79) == 0);
      swr   = ($urandom_range(0, 19) == 0);
      wdt   = ($urandom_range(0, 19) == 0);
      ill   = ($urandom_range(0, 29) == 0);
      uni   = ($urandom_range(0, 29) == 0);
      tp    = ($urandom_range(0, 3) == 0) ? NT'($urandom) : '0;
      slp   = ($urandom_range(0, 5) == 0);
      idl   = ($urandom_range(0, 5) == 0);
      psv   = ($urandom_range(0, 9) == 0);
      we    = ($urandom_range(0, 7) == 0);
      wd    = 16'($urandom);
      cycle("R9 random");
    end
    idle_in();
    for (int i = 0; i < P + 4; i++) cycle("R9 settle");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule